// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Back End

This block is the digital half of a four-stage pipelined analog-to-digital converter. Every stage resolves a 4-bit coarse code. Stage gain is 8, so each code carries one bit of overlap with its neighbour. The stages run on alternating clock phases. The code that stage 1 produces for a sample therefore arrives half a conversion period before the stage 2 code for that sample, and so on down to stage 4. The block holds the earlier codes in per-stage shift lines until all four codes of one sample line up. It then adds them with 3-bit spacing between stage weights and removes the fixed bias that the overlap introduces. This sum cancels a stage decision error in either direction. The block clamps the result to the 12-bit range and registers it onto an offset-binary output bus, three conversion periods after the sampling edge.

The block runs on a clock at twice the conversion rate (one edge per half period). After reset, the first edge is a sampling edge. From then on, sampling edges and mid-period edges alternate. The output register changes only on sampling edges. A valid flag marks the first real word.

Top module: `adc_corr_backend`

## Requirements
- R1: In the packed `stage_codes` input, stage k (k = 1..4) sits at bits [4k-1:4k-4], so stage 1 is in the low nibble. For aligned codes c1..c4, the word is c1*512 + c2*64 + c3*8 + c4 - 2340, as long as that value lies in 0..4095.
- R2: When that sum exceeds 4095, the word is 4095 (all ones, positive full scale).
- R3: When that sum is below zero, the word is 0 (all zeros, negative full scale).
- R4: Number the half-period edges from 0, the first edge with reset low. Edge 2n samples sample n. Stage k's code for sample n is the value present at edge 2n+k. Values the stage inputs carry at any other edge have no effect on any word.
- R5: The word for sample n appears on the output just after edge 2n+6, which is three conversion periods after its sampling edge. Sample n+1 follows one period later.
- R6: The output word and the valid flag change only at even-numbered edges. After an odd edge they hold their previous value.
- R7: The valid flag is low after edges 0, 2 and 4 and goes high at edge 6. It stays high until the next reset.
- R8: While the synchronous active-high reset is asserted, the word is 0, the valid flag is 0, and the delay lines are emptied. Edge numbering restarts at the first edge after reset is released.
- R9: Stage decisions that sit up to half a stage step above or below the ideal split of a value still yield exactly that value. The next stage codes carry the residue, and the code range holds 0..15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_h | input | 1 | Half-period clock, two edges per conversion |
| rst | input | 1 | Synchronous active-high reset |
| stage_codes | input | 16 | Four stage codes, stage 1 in the low nibble |
| word_o | output | 12 | Corrected offset-binary word, registered |
| word_valid_o | output | 1 | High once the pipeline has filled |

## Verification
The hardest condition to reach is a correction in both directions that must still land on the exact value, including at the clamp edges. One stage decides one step high or low, and a later stage must absorb the difference. The bench builds each sample from a known 12-bit value by pushing every stage decision off by a random amount of up to half a step. It also drives hand-built code sets that land at -1, 0, 4095 and 4096 before clamping. At each edge where a stage input does not belong to any sample, that input carries random junk. A word that matches its sample in the exact expected period therefore shows that the alignment ignored the junk.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  // Left shift applied to stage idx (0 = first stage) when merging.
  function automatic int stage_shift(input int idx, input int nstg, input int step);
    return step * (nstg - 1 - idx);
  endfunction

  // Total bias: every stage code is centred on a quarter of its range.
  function automatic int bias_total(input int nstg, input int step, input int code_w);
    int acc;
    acc = 0;
    for (int j = 0; j < nstg; j++) acc += (1 << (code_w - 2)) << (step * j);
    return acc;
  endfunction

endpackage

// File: rtl/adc_corr_delay.sv
module adc_corr_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) sr[j] <= '0;
    end else begin
      sr[0] <= d;
      for (int j = 1; j < DEPTH; j++) sr[j] <= sr[j-1];
    end
  end

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/adc_corr_merge.sv
module adc_corr_merge
  import adc_corr_pkg::*;
#(
  parameter int NSTG   = 4,
  parameter int CODE_W = 4,
  parameter int STEP   = 3,
  parameter int OUT_W  = 12
) (
  input  logic [NSTG*CODE_W-1:0] codes,
  output logic [OUT_W-1:0]       word
);

  localparam int SUM_W = OUT_W + CODE_W + 1;
  localparam int BIAS  = bias_total(NSTG, STEP, CODE_W);
  localparam logic signed [SUM_W-1:0] BIAS_V = SUM_W'(BIAS);
  localparam logic signed [SUM_W-1:0] TOP_V  = SUM_W'((1 << OUT_W) - 1);

  logic signed [SUM_W-1:0] acc;
  logic        [SUM_W-1:0] term;

  always_comb begin
    acc  = -BIAS_V;
    term = '0;
    for (int i = 0; i < NSTG; i++) begin
      term = SUM_W'(codes[i*CODE_W +: CODE_W]) << stage_shift(i, NSTG, STEP);
      acc  = acc + $signed(term);
    end
    if (acc < 0)          word = '0;
    else if (acc > TOP_V) word = '1;
    else                  word = acc[OUT_W-1:0];
  end

endmodule

// File: rtl/adc_corr_frame.sv
module adc_corr_frame #(
  parameter int FILL = 3
) (
  input  logic clk,
  input  logic rst,
  output logic upd,
  output logic full
);

  localparam int CW = $clog2(FILL + 1);

  logic          odd;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd <= 1'b0;
      cnt <= '0;
    end else begin
      odd <= ~odd;
      if (!odd && cnt != CW'(FILL)) cnt <= cnt + 1'b1;
    end
  end

  assign upd  = ~odd;
  assign full = (cnt == CW'(FILL));

endmodule

// File: rtl/adc_corr_backend.sv
module adc_corr_backend #(
  parameter int NSTG   = 4,
  parameter int CODE_W = 4,
  parameter int STEP   = 3,
  parameter int OUT_W  = 12
) (
  input  logic                   clk_h,
  input  logic                   rst,
  input  logic [NSTG*CODE_W-1:0] stage_codes,
  output logic [OUT_W-1:0]       word_o,
  output logic                   word_valid_o
);

  localparam int FILL = (NSTG + 2) / 2;

  logic [NSTG*CODE_W-1:0] aligned;
  logic [OUT_W-1:0]       merged;
  logic                   upd_en;
  logic                   pipe_full;

  // Stage i lands one half period after stage i-1, so it needs one fewer register.
  for (genvar i = 0; i < NSTG; i++) begin : g_line
    adc_corr_delay #(.W(CODE_W), .DEPTH(NSTG + 1 - i)) u_line (
      .clk(clk_h),
      .rst(rst),
      .d  (stage_codes[i*CODE_W +: CODE_W]),
      .q  (aligned[i*CODE_W +: CODE_W])
    );
  end

  adc_corr_merge #(.NSTG(NSTG), .CODE_W(CODE_W), .STEP(STEP), .OUT_W(OUT_W)) u_merge (
    .codes(aligned),
    .word (merged)
  );

  adc_corr_frame #(.FILL(FILL)) u_frame (
    .clk (clk_h),
    .rst (rst),
    .upd (upd_en),
    .full(pipe_full)
  );

  always_ff @(posedge clk_h) begin
    if (rst) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else if (upd_en) begin
      word_o       <= merged;
      word_valid_o <= pipe_full;
    end
  end

endmodule

// File: rtl/adc_corr_checks.sv
module adc_corr_checks #(
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             upd,
  input logic [OUT_W-1:0] word,
  input logic             valid
);

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !$past(upd)) |-> ($stable(word) && $stable(valid)));

  assert_phase_alternates_R6: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (upd != $past(upd)));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!valid && word == '0));

  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(valid)) |-> valid);

  assert_valid_rises_on_update_R7: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $rose(valid)) |-> $past(upd));

endmodule

bind adc_corr_backend adc_corr_checks #(.OUT_W(OUT_W)) u_chk (
  .clk  (clk_h),
  .rst  (rst),
  .upd  (upd_en),
  .word (word_o),
  .valid(word_valid_o)
);

// File: tb/adc_corr_backend_bench.sv
module adc_corr_backend_bench;

  localparam int PER = 10;
  localparam int NS  = 140;

  logic        clk_h = 1'b0;
  logic        rst   = 1'b1;
  logic [15:0] stage_codes = '0;
  logic [11:0] word_o;
  logic        word_valid_o;

  int    code_tab [NS][4];
  int    exp_tab  [NS];
  string tag_tab  [NS];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  always #(PER/2) clk_h = ~clk_h;

  adc_corr_backend u_adc_corr_backend (
    .clk_h       (clk_h),
    .rst         (rst),
    .stage_codes (stage_codes),
    .word_o      (word_o),
    .word_valid_o(word_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int floor_div(input int a, input int b);
    int q;
    q = a / b;
    if ((a % b) != 0 && a < 0) q--;
    return q;
  endfunction

  // R1/R2/R3: weighted sum minus bias, clamped to 0..4095
  function automatic int word_of(input int idx);
    int s;
    s = code_tab[idx][0]*512 + code_tab[idx][1]*64 + code_tab[idx][2]*8
        + code_tab[idx][3] - 2340;
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return s;
  endfunction

  // Build stage codes from a value, each decision skewed by t (R9)
  task automatic put_value(input int idx, input int v, input int t1, input int t2, input int t3);
    int r, c;
    int wt [3];
    int tt [3];
    wt = '{512, 64, 8};
    tt = '{t1, t2, t3};
    r = v;
    for (int s = 0; s < 3; s++) begin
      c = floor_div(r + tt[s], wt[s]) + 4;
      if (c < 0 || c > 15) c = floor_div(r, wt[s]) + 4;
      code_tab[idx][s] = c;
      r = r - (c - 4) * wt[s];
    end
    code_tab[idx][3] = r + 4;
    exp_tab[idx] = word_of(idx);
    tag_tab[idx] = (t1 != 0 || t2 != 0 || t3 != 0) ? "R9" : "R1";
    if (exp_tab[idx] != v) begin
      checks++; fails++;
      $display("FAIL R9 bench encoding actual=%0d expected=%0d", exp_tab[idx], v);
    end
  endtask

  task automatic put_raw(input int idx, input int a, input int b, input int c, input int d,
                         input string tag);
    code_tab[idx][0] = a; code_tab[idx][1] = b;
    code_tab[idx][2] = c; code_tab[idx][3] = d;
    exp_tab[idx] = word_of(idx);
    tag_tab[idx] = tag;
  endtask

  function automatic int rnd_skew(input int half);
    if ($urandom % 2 == 0) return 0;
    return int'($urandom % (2*half)) - half;
  endfunction

  task automatic fill_random(input int first);
    for (int i = first; i < NS; i++)
      put_value(i, int'($urandom % 4096), rnd_skew(256), rnd_skew(32), rnd_skew(4));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk_h);
    #(PER/4);
    chk(word_o == 12'd0, "R8 word in reset", int'(word_o), 0);
    chk(word_valid_o == 1'b0, "R8 valid in reset", int'(word_valid_o), 0);
    rst = 1'b0;
  endtask

  // Edge k after reset: stage s+1 value for sample n belongs to edge 2n+s+1 (R4)
  task automatic run_block();
    int last;
    last = int'(word_o);
    for (int k = 0; k < 2*NS + 6; k++) begin
      for (int s = 0; s < 4; s++) begin
        int n2;
        n2 = k - (s + 1);
        if (n2 >= 0 && n2 % 2 == 0 && n2/2 < NS)
          stage_codes[s*4 +: 4] = 4'(code_tab[n2/2][s]);
        else
          stage_codes[s*4 +: 4] = 4'($urandom % 16);
      end
      @(posedge clk_h);
      #(PER/4);
      if (k % 2 == 1) begin
        chk(int'(word_o) == last, "R6 word held at odd edge", int'(word_o), last);
      end else begin
        int m;
        m = k / 2;
        chk(word_valid_o == (m >= 3), "R7 valid flag", int'(word_valid_o), int'(m >= 3));
        if (m >= 3)
          chk(int'(word_o) == exp_tab[m-3], {"R4 R5 ", tag_tab[m-3], " word"},
              int'(word_o), exp_tab[m-3]);
      end
      last = int'(word_o);
    end
  endtask

  initial begin
    void'($urandom(32'd5805));
    // directed corner cases
    put_value(0, 0, 0, 0, 0);
    put_value(1, 4095, 255, 31, 3);
    put_value(2, 2047, -256, -32, -4);
    put_value(3, 2048, 255, -32, 3);
    put_raw(4, 15, 15, 15, 15, "R2");
    put_raw(5, 0, 0, 0, 0, "R3");
    put_raw(6, 4, 4, 4, 3, "R3");
    put_raw(7, 4, 4, 4, 4, "R1");
    put_raw(8, 12, 4, 4, 3, "R1");
    put_raw(9, 12, 4, 4, 4, "R2");
    put_raw(10, 11, 15, 15, 15, "R2");
    put_raw(11, 3, 0, 0, 0, "R3");
    put_value(12, 1, -256, 31, -4);
    put_value(13, 4094, 128, -20, 2);
    fill_random(14);
    do_reset();
    run_block();
    // reset mid-stream, then a fresh random set
    fill_random(0);
    do_reset();
    run_block();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PER * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule